// File: doc/BRIEF.md
# Nine-bit serial command/data writer

This block is a write-only serial master for the control port of a display controller. One request produces one transaction: a command byte, optionally followed by one or two data bytes. Each byte leaves the block as a 9-bit word. The top bit of the word says whether the byte is a command or data. A 16-bit value is split into two data words, and the high byte goes first.

The host side is a simple request input. The host presents an address, a length code and a 16-bit value, and the request is taken in any cycle where the block is not busy. The line side drives chip select, serial clock and serial data. The clock idles high and the device samples data on the rising edge. There is no receive line, so nothing is ever read back from the device. The serial bit time is a parameter, DIV, counted in system clocks.

Top module: `nsw_spi_writer`

## Requirements
- R1: A request is taken only in a cycle where `req_valid` is high and `busy` is low. A request presented while `busy` is high produces no frame.
- R2: Every word is 9 bits wide. Bit 8 is 0 for the command word and 1 for each data word. Bits 7..0 carry the byte, and the command word carries `req_addr`.
- R3: Length code 0 sends one word, code 1 sends two words and code 2 sends three words. Code 3 is sent as code 2.
- R4: With code 1 the single data word carries `req_data[7:0]`. With code 2 the first data word carries `req_data[15:8]` and the second carries `req_data[7:0]`.
- R5: Each word is shifted MSB first, so the command/data flag bit is the first bit on the line.
- R6: Each bit lasts DIV system clocks: `sclk` is low for the first DIV/2 clocks and high for the rest. `sdo` changes only while `sclk` is low. `sclk` is high whenever `cs_n` is high.
- R7: `cs_n` stays low without a break for the whole frame, for exactly 9 × words × DIV clocks.
- R8: After `cs_n` rises, `busy` stays high for DIV clocks with `cs_n` high. `done` is then high for exactly one clock, DIV clocks after the rise of `cs_n`, with `busy` low in that clock.
- R9: After reset, `cs_n` = 1, `sclk` = 1, `sdo` = 0, `busy` = 0 and `done` = 0.
- R10: `busy` and a low `cs_n` appear in the clock that follows the one in which a request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_addr | input | 8 | Command byte |
| req_len | input | 2 | Data length code (0, 1, 2; 3 is sent as 2) |
| req_data | input | 16 | Data value |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-clock pulse at the end of a transaction |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |

## Verification
Every output is decoded from flops, so `busy` and the fall of `cs_n` are due one clock after the accepting edge. Rising `sclk` edges follow at DIV/2 clocks into each bit. The rise of `cs_n` comes 9 × words × DIV clocks after its fall, and `done` comes DIV clocks after that. The monitor samples on the falling system clock edge and counts clocks from the fall and the rise of `cs_n`. It checks each rising-edge bit position, the length of the low chip select and the distance to `done` against these figures. The driver checks `busy` in the clock after the request.

// File: rtl/nsw_pkg.sv
package nsw_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = BYTE_W + 1;
  localparam int MAX_DATA  = 2;
  localparam int DATA_W    = BYTE_W * MAX_DATA;
  localparam int MAX_WORDS = MAX_DATA + 1;
  localparam int FRAME_W   = WORD_W * MAX_WORDS;
  localparam int LEN_W     = $clog2(MAX_DATA + 1);
  localparam int CNT_W     = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} nsw_state_e;

  // length codes above the largest supported count are sent at that count
  function automatic int eff_len(logic [LEN_W-1:0] len);
    int n;
    n = int'(len);
    if (n > MAX_DATA) n = MAX_DATA;
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] frame_bits(logic [LEN_W-1:0] len);
    return CNT_W'(WORD_W * (eff_len(len) + 1));
  endfunction

  function automatic logic [WORD_W-1:0] make_word(logic is_data, logic [BYTE_W-1:0] b);
    return {is_data, b};
  endfunction
endpackage

// File: rtl/nsw_frame_packer.sv
module nsw_frame_packer
  import nsw_pkg::*;
(
  input  logic [BYTE_W-1:0]  addr,
  input  logic [LEN_W-1:0]   len,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  int n_data;
  assign n_data = eff_len(len);
  assign nbits  = frame_bits(len);

  // slot 0: the command word, flag clear
  assign frame[FRAME_W-1 -: WORD_W] = make_word(1'b0, addr);

  // slot s carries data byte (n_data - s): most significant byte first
  for (genvar s = 1; s < MAX_WORDS; s++) begin : g_slot
    logic [WORD_W-1:0] w;
    always_comb begin
      w = '0;
      for (int k = 0; k < MAX_DATA; k++) begin
        if (s <= n_data && k == n_data - s)
          w = make_word(1'b1, data[k*BYTE_W +: BYTE_W]);
      end
    end
    assign frame[FRAME_W-1-s*WORD_W -: WORD_W] = w;
  end
endmodule

// File: rtl/nsw_bit_timer.sv
module nsw_bit_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic bit_end,
  output logic first_half
);
  localparam int HALF = DIV / 2;
  localparam int TW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [TW-1:0] cnt;

  assign bit_end    = run && (cnt == TW'(DIV - 1));
  assign first_half = run && (cnt < TW'(HALF));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (bit_end) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R6: the phase counter never leaves one bit time
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(DIV - 1));
endmodule

// File: rtl/nsw_shifter.sv
module nsw_shifter
  import nsw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  input  logic               step,
  output logic               sdo,
  output logic               last_bit
);
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   rem;

  assign sdo      = sh[FRAME_W-1];
  assign last_bit = (rem == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      rem <= '0;
    end else if (load) begin
      sh  <= frame_in;
      rem <= nbits_in;
    end else if (step && rem != '0) begin
      // the last bit stays on the line until the next load
      if (!last_bit) sh <= {sh[FRAME_W-2:0], 1'b0};
      rem <= rem - 1'b1;
    end
  end

  // R7: a bit step never happens with no bits left
  p_no_underrun_r7: assert property (@(posedge clk) disable iff (rst)
    step |-> rem != '0);
  // R3: a load always brings a whole number of words
  p_load_words_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (rem == CNT_W'(WORD_W) || rem == CNT_W'(2*WORD_W) || rem == CNT_W'(3*WORD_W)));
endmodule

// File: rtl/nsw_spi_writer.sv
module nsw_spi_writer
  import nsw_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BYTE_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo
);
  nsw_state_e state;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic accept, bit_end, first_half, last_bit, step, frame_end, gap_end;

  assign accept    = req_valid && (state == ST_IDLE);
  assign step      = (state == ST_SHIFT) && bit_end;
  assign frame_end = step && last_bit;
  assign gap_end   = (state == ST_GAP) && bit_end;

  nsw_frame_packer u_pack (
    .addr (req_addr), .len (req_len), .data (req_data),
    .frame (frame), .nbits (nbits)
  );

  nsw_bit_timer #(.DIV(DIV)) u_timer (
    .clk (clk), .rst (rst), .run (state != ST_IDLE),
    .bit_end (bit_end), .first_half (first_half)
  );

  nsw_shifter u_shift (
    .clk (clk), .rst (rst), .load (accept),
    .frame_in (frame), .nbits_in (nbits), .step (step),
    .sdo (sdo), .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= gap_end;
      unique case (state)
        ST_IDLE:  if (accept)    state <= ST_SHIFT;
        ST_SHIFT: if (frame_end) state <= ST_GAP;
        ST_GAP:   if (bit_end)   state <= ST_IDLE;
        default:                 state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign cs_n = (state != ST_SHIFT);
  assign sclk = !((state == ST_SHIFT) && first_half);

  // R6: clock parked high whenever the device is deselected
  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);
  // R6: data moves only in the low half of a bit
  p_sdo_change_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> !sclk);
  // R8: done is a single pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: done arrives with the block already free
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && cs_n);
  // R8: release of chip select is followed by a busy gap
  p_cs_release_busy_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> busy);
  // R10: a taken request shows busy and selects the device next clock
  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (busy && !cs_n));
  // R1: busy only starts from a request
  p_busy_source_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/nsw_spi_writer_test.sv
module nsw_spi_writer_test;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [7:0] req_addr = '0;
  logic [1:0] req_len = '0;
  logic [15:0] req_data = '0;
  logic busy, done, cs_n, sclk, sdo;

  always #4 clk = ~clk;

  nsw_spi_writer #(.DIV(DIV)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_data(req_data), .busy(busy), .done(done),
    .cs_n(cs_n), .sclk(sclk), .sdo(sdo)
  );

  int checks = 0;
  int errors = 0;
  int frames_sent = 0;
  int frames_seen = 0;
  int exp_cnt_q[$];
  logic [8:0] exp_word_q[$];

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // driver: waits for a free block, presents one request, queues the expected words
  task automatic send(logic [7:0] a, logic [1:0] l, logic [15:0] d);
    int n;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_data = d;
    n = (l > 2) ? 2 : int'(l);
    exp_cnt_q.push_back(n + 1);
    exp_word_q.push_back({1'b0, a});
    if (n == 2) begin
      exp_word_q.push_back({1'b1, d[15:8]});
      exp_word_q.push_back({1'b1, d[7:0]});
    end else if (n == 1) begin
      exp_word_q.push_back({1'b1, d[7:0]});
    end
    frames_sent++;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1 && cs_n === 1'b0, "R10", {busy, cs_n}, 2'b10);
  endtask

  // drive junk requests while the block is busy; none may produce a frame (R1)
  task automatic poke_busy(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      req_valid = busy;
      req_addr = 8'h5A; req_len = 2'd2; req_data = 16'hDEAD;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  logic [26:0] bits_sh = '0;
  int nbit = 0, cs_cycles = 0, gap = 0;
  bit in_gap = 0, idle_bad = 0, timing_bad = 0, stray_done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n && !sclk) idle_bad = 1;
      if (in_gap) begin
        if (done) begin
          // done arrives DIV samples after the one where cs_n rose
          chk(gap == DIV - 1, "R8 gap", gap, DIV - 1);
          chk(busy === 1'b0, "R8 busy at done", busy, 0);
          in_gap = 0;
        end else begin
          chk(busy === 1'b1 && cs_n === 1'b1, "R8 gap state", {busy, cs_n}, 2'b11);
          gap++;
        end
      end else if (done) stray_done = 1;
      if (!cs_n) begin
        if (sclk && !prev_sclk) begin
          if ((cs_cycles % DIV) != HALF) timing_bad = 1;
          bits_sh = {bits_sh[25:0], sdo};
          nbit++;
        end
        cs_cycles++;
      end
      if (cs_n && !prev_cs) begin
        int n;
        frames_seen++;
        in_gap = 1; gap = 0;
        if (exp_cnt_q.size() == 0) begin
          chk(0, "R1 unexpected frame", nbit, 0);
        end else begin
          n = exp_cnt_q.pop_front();
          chk(nbit == 9 * n, "R3 bit count", nbit, 9 * n);
          chk(cs_cycles == 9 * n * DIV, "R7 cs low length", cs_cycles, 9 * n * DIV);
          chk(!timing_bad, "R6 rising edge position", timing_bad, 0);
          for (int w = 0; w < n; w++) begin
            logic [8:0] got, exp;
            got = 9'((bits_sh >> (9 * (n - 1 - w))) & 27'h1FF);
            exp = exp_word_q.pop_front();
            chk(got == exp, w == 0 ? "R2 R5 command word" : "R4 R5 data word", got, exp);
          end
        end
        nbit = 0; cs_cycles = 0; bits_sh = '0; timing_bad = 0;
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  bit finished = 0;

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cs_n, sclk, sdo, busy, done} === 5'b11000, "R9 reset state",
        {cs_n, sclk, sdo, busy, done}, 5'b11000);
    rst = 1'b0;
    @(negedge clk);
    send(8'h11, 2'd0, 16'h0000);        // command alone
    send(8'hB6, 2'd1, 16'h0040);        // one data byte
    send(8'hB8, 2'd2, 16'hFFF9);        // 16-bit value, high byte first
    send(8'hC3, 2'd2, 16'h2040);
    send(8'h3B, 2'd3, 16'h1234);        // R3: code 3 sent as code 2
    send(8'h3A, 2'd1, 16'hAB60);        // R4: only the low byte goes out
    poke_busy(30);                      // R1
    send(8'h00, 2'd0, 16'hFFFF);
    send(8'hFF, 2'd2, 16'hFFFF);
    send(8'h80, 2'd2, 16'h0100);
    @(negedge clk);
    while (busy || done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(frames_seen == frames_sent, "R1 frame count", frames_seen, frames_sent);
    chk(exp_cnt_q.size() == 0, "R1 queue drained", exp_cnt_q.size(), 0);
    chk(!idle_bad, "R6 sclk high while deselected", idle_bad, 0);
    chk(!stray_done, "R8 no stray done", stray_done, 0);
    finished = 1;
    summary();
  end
endmodule